// File: doc/BRIEF.md
# Multi-Source XOR and P+Q Parity Engine

This block is a streaming parity engine that combines several source word streams into redundancy words. In the plain mode it produces one P word per word position, the XOR of every selected source at that position. In P+Q mode it also produces a Q word. For the Q word, each byte of each source is multiplied in GF(2^8) by a per-source 8-bit coefficient, and the products are XOR-summed.

A single 32-bit control word chooses the operation. In P+Q mode the P word can be suppressed. A checking mode discards the results and only records whether any P or Q word came out nonzero. A fill mode emits a constant word and reads no source. At the end the engine can present one status word that carries the byte count, the two nonzero flags and a completion flag.

The surrounding logic supplies the control word, a byte count, the coefficients and the fill value with a one-cycle `start_i` pulse. It then feeds sources over per-source valid/ready streams and takes results over a valid/ready output stream. Address generation and memory access belong to the surrounding logic.

Top module: `parity_engine`

## Requirements
- R1: The control word is decoded as follows: bit 0 interrupt enable, bits 6:3 source count minus one (1 to 16 sources), bit 7 zero-check, bit 8 fill, bit 12 status write-back, bit 17 P+Q enable, bit 18 P suppress. Bits 2:1 and all other bits are ignored.
- R2: For each word position, the P word equals the XOR of the selected sources' words at that position. Sources are read one beat at a time in ascending index order, and at most one `src_ready_o` bit is high in any cycle.
- R3: In P+Q mode the Q word is the XOR, over the selected sources, of each source byte multiplied in GF(2^8) (polynomial 0x11D) by that source's coefficient. The coefficient of source s is `coef_i[8s+7:8s]`. For each word position the P word (`out_tag_o`=0) comes before the Q word (`out_tag_o`=1).
- R4: With P+Q enabled and P suppress set, only Q words are output. P suppress has no effect when P+Q is off.
- R5: In zero-check mode no result word is output. Status bit 30 is set if any P word was nonzero, and bit 29 is set if P+Q is on and any Q word was nonzero.
- R6: `stat_valid_o` is high exactly in the `done_o` cycle, and only when write-back is set. The status word has bit 31 set and the byte count in bits 23:0.
- R7: In fill mode `fill_i` is output once per word position and no source beat is accepted.
- R8: The number of word positions is the byte count divided by 4, rounded up. A partial last word counts as a full word.
- R9: A byte count of zero moves no data, and `done_o` rises in the second cycle after the start pulse is accepted.
- R10: While `out_valid_o` is high and `out_ready_i` is low, the output word and tag hold steady. While the selected source is not valid, the same `src_ready_o` bit stays high.
- R11: `irq_o` is high in the `done_o` cycle only when interrupt enable is set.
- R12: After reset, and whenever idle, `busy_o`, `out_valid_o`, `done_o` and all `src_ready_o` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| ctrl_i | input | 32 | Operation control word |
| byte_cnt_i | input | CNT_W (24) | Transfer length in bytes |
| coef_i | input | NSRC*8 (128) | Per-source GF(2^8) coefficients |
| fill_i | input | WORD_W (32) | Fill-mode constant |
| src_data_i | input | NSRC*WORD_W (512) | Source words, source s at slice s |
| src_valid_i | input | NSRC (16) | Source word valid |
| src_ready_o | output | NSRC (16) | Source word accepted |
| out_data_o | output | WORD_W (32) | Result word |
| out_tag_o | output | 1 | 0 for a P or fill word, 1 for a Q word |
| out_valid_o | output | 1 | Result word valid |
| out_ready_i | input | 1 | Result word accepted |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| irq_o | output | 1 | Interrupt pulse |
| stat_valid_o | output | 1 | Status word valid |
| stat_word_o | output | 32 | Completion status |

## Verification
The assertions check the protocol rules on every cycle: one-hot source readiness, held source selection and held output under stall, no output in zero-check mode, no source reads in fill mode, and quiet idle with single-cycle done, status and interrupt pulses. Only the bench scenarios can show the arithmetic. These include the P and Q values across different source counts and data patterns, an exhaustive sweep of every coefficient against every byte value, the rounding of word counts, the flag outcomes of the checking mode, and the exact status word and completion latency.

// File: rtl/pe_pkg.sv
package pe_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LOAD,
      S_READ,
      S_EMIT_P,
      S_EMIT_Q,
      S_FILL,
      S_DONE
   } pe_state_e;

   typedef struct packed {
      logic       p_off;
      logic       pq_on;
      logic       wback;
      logic       fill;
      logic       zchk;
      logic [3:0] nsel;
      logic       irq_en;
   } pe_cfg_t;

   function automatic pe_cfg_t decode_ctrl(input logic [31:0] c);
      pe_cfg_t r;
      r.irq_en = c[0];
      r.nsel   = c[6:3];
      r.zchk   = c[7];
      r.fill   = c[8];
      r.wback  = c[12];
      r.pq_on  = c[17];
      r.p_off  = c[18];
      return r;
   endfunction

   // carry-less product followed by modular reduction
   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [8:0] poly);
      logic [14:0] t;
      t = '0;
      for (int i = 0; i < 8; i++)
         if (b[i]) t = t ^ (15'(a) << i);
      for (int i = 14; i >= 8; i--)
         if (t[i]) t = t ^ (15'(poly) << (i - 8));
      return t[7:0];
   endfunction

endpackage

// File: rtl/pe_gf_lane.sv
module pe_gf_lane #(
   parameter logic [8:0] POLY = 9'h11D
) (
   input  logic [7:0] a_i,
   input  logic [7:0] b_i,
   output logic [7:0] y_o
);
   always_comb y_o = pe_pkg::gf_mul(a_i, b_i, POLY);
endmodule

// File: rtl/pe_accum.sv
module pe_accum #(
   parameter int         WORD_W = 32,
   parameter logic [8:0] POLY   = 9'h11D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              beat_i,
   input  logic              first_i,
   input  logic              last_i,
   input  logic              zchk_i,
   input  logic              pq_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic [7:0]        coef_i,
   output logic [WORD_W-1:0] p_o,
   output logic [WORD_W-1:0] q_o,
   output logic              pflag_o,
   output logic              qflag_o
);
   localparam int LANES = WORD_W / 8;

   logic [WORD_W-1:0] q_term, p_next, q_next;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         pe_gf_lane #(.POLY(POLY)) u_mul (
            .a_i(data_i[8*l +: 8]),
            .b_i(coef_i),
            .y_o(q_term[8*l +: 8])
         );
      end
   endgenerate

   always_comb begin
      p_next = first_i ? data_i : (p_o ^ data_i);
      q_next = first_i ? q_term : (q_o ^ q_term);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_o     <= '0;
         q_o     <= '0;
         pflag_o <= 1'b0;
         qflag_o <= 1'b0;
      end else begin
         if (clr_i) begin
            pflag_o <= 1'b0;
            qflag_o <= 1'b0;
         end else if (beat_i && last_i && zchk_i) begin
            pflag_o <= pflag_o | (|p_next);
            qflag_o <= qflag_o | (pq_i & (|q_next));
         end
         if (beat_i) begin
            p_o <= p_next;
            q_o <= q_next;
         end
      end
   end
endmodule

// File: rtl/pe_ctl.sv
module pe_ctl
   import pe_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int WC_W  = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [WC_W-1:0]  words_i,
   input  logic             fill_i,
   input  logic             pq_i,
   input  logic             p_off_i,
   input  logic             zchk_i,
   input  logic [IDX_W-1:0] last_idx_i,
   input  logic             src_fire_i,
   input  logic             out_fire_i,
   output pe_state_e        state_o,
   output logic [IDX_W-1:0] idx_o
);
   pe_state_e        st_n;
   logic [IDX_W-1:0] idx_n;
   logic [WC_W-1:0]  wleft, wleft_n;
   pe_state_e        adv_st;
   logic [WC_W-1:0]  adv_wl;

   // state entered after a word position has been fully handled
   always_comb begin
      if (wleft == WC_W'(1)) begin
         adv_st = S_DONE;
         adv_wl = '0;
      end else begin
         adv_st = fill_i ? S_FILL : S_READ;
         adv_wl = wleft - WC_W'(1);
      end
   end

   always_comb begin
      st_n    = state_o;
      idx_n   = idx_o;
      wleft_n = wleft;
      unique case (state_o)
         S_IDLE: if (start_i) st_n = S_LOAD;
         S_LOAD: begin
            idx_n   = '0;
            wleft_n = words_i;
            if (words_i == '0) st_n = S_DONE;
            else if (fill_i)   st_n = S_FILL;
            else               st_n = S_READ;
         end
         S_READ: if (src_fire_i) begin
            if (idx_o == last_idx_i) begin
               idx_n = '0;
               if (zchk_i) begin
                  st_n    = adv_st;
                  wleft_n = adv_wl;
               end else begin
                  st_n = (pq_i && p_off_i) ? S_EMIT_Q : S_EMIT_P;
               end
            end else begin
               idx_n = idx_o + IDX_W'(1);
            end
         end
         S_EMIT_P: if (out_fire_i) begin
            if (pq_i) st_n = S_EMIT_Q;
            else begin
               st_n    = adv_st;
               wleft_n = adv_wl;
            end
         end
         S_EMIT_Q, S_FILL: if (out_fire_i) begin
            st_n    = adv_st;
            wleft_n = adv_wl;
         end
         S_DONE:  st_n = S_IDLE;
         default: st_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o <= S_IDLE;
         idx_o   <= '0;
         wleft   <= '0;
      end else begin
         state_o <= st_n;
         idx_o   <= idx_n;
         wleft   <= wleft_n;
      end
   end
endmodule

// File: rtl/parity_engine.sv
module parity_engine
   import pe_pkg::*;
#(
   parameter int         NSRC   = 16,
   parameter int         WORD_W = 32,
   parameter int         CNT_W  = 24,
   parameter logic [8:0] POLY   = 9'h11D
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [31:0]            ctrl_i,
   input  logic [CNT_W-1:0]       byte_cnt_i,
   input  logic [NSRC*8-1:0]      coef_i,
   input  logic [WORD_W-1:0]      fill_i,
   input  logic [NSRC*WORD_W-1:0] src_data_i,
   input  logic [NSRC-1:0]        src_valid_i,
   output logic [NSRC-1:0]        src_ready_o,
   output logic [WORD_W-1:0]      out_data_o,
   output logic                   out_tag_o,
   output logic                   out_valid_o,
   input  logic                   out_ready_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic                   irq_o,
   output logic                   stat_valid_o,
   output logic [31:0]            stat_word_o
);
   localparam int BPW    = WORD_W / 8;
   localparam int LG_BPW = $clog2(BPW);
   localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam int WC_W   = CNT_W + 1;

   generate
      if (NSRC < 1 || NSRC > 16) begin : g_bad_nsrc
         $error("parity_engine: NSRC must lie in 1..16");
      end
      if (WORD_W % 8 != 0 || (1 << LG_BPW) != BPW) begin : g_bad_word
         $error("parity_engine: WORD_W must be 8 times a power of two");
      end
      if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
         $error("parity_engine: CNT_W must lie in 1..24");
      end
   endgenerate

   pe_cfg_t             cfg_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [NSRC*8-1:0]   coef_q;
   logic [WORD_W-1:0]   fill_q;
   pe_state_e           state;
   logic [IDX_W-1:0]    idx;
   logic [IDX_W-1:0]    last_idx;
   logic [WC_W-1:0]     wsum, words;
   logic [WORD_W-1:0]   sel_data;
   logic [7:0]          sel_coef;
   logic                sel_valid;
   logic                src_fire, out_fire;
   logic [WORD_W-1:0]   p_acc, q_acc;
   logic                pflag, qflag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         cnt_q  <= '0;
         coef_q <= '0;
         fill_q <= '0;
      end else if (state == S_IDLE && start_i) begin
         cfg_q  <= decode_ctrl(ctrl_i);
         cnt_q  <= byte_cnt_i;
         coef_q <= coef_i;
         fill_q <= fill_i;
      end
   end

   always_comb begin
      if (int'(cfg_q.nsel) > NSRC - 1) last_idx = IDX_W'(NSRC - 1);
      else                             last_idx = IDX_W'(cfg_q.nsel);
      wsum  = {1'b0, cnt_q} + WC_W'(BPW - 1);
      words = wsum >> LG_BPW;
   end

   // source and coefficient selection by current index
   always_comb begin
      sel_data    = '0;
      sel_coef    = '0;
      sel_valid   = 1'b0;
      src_ready_o = '0;
      for (int s = 0; s < NSRC; s++) begin
         if (idx == IDX_W'(s)) begin
            sel_data       = src_data_i[s*WORD_W +: WORD_W];
            sel_coef       = coef_q[s*8 +: 8];
            sel_valid      = src_valid_i[s];
            src_ready_o[s] = (state == S_READ);
         end
      end
   end

   assign src_fire = (state == S_READ) && sel_valid;
   assign out_fire = out_valid_o && out_ready_i;

   pe_ctl #(.IDX_W(IDX_W), .WC_W(WC_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .words_i    (words),
      .fill_i     (cfg_q.fill),
      .pq_i       (cfg_q.pq_on),
      .p_off_i    (cfg_q.p_off),
      .zchk_i     (cfg_q.zchk),
      .last_idx_i (last_idx),
      .src_fire_i (src_fire),
      .out_fire_i (out_fire),
      .state_o    (state),
      .idx_o      (idx)
   );

   pe_accum #(.WORD_W(WORD_W), .POLY(POLY)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (state == S_LOAD),
      .beat_i  (src_fire),
      .first_i (idx == '0),
      .last_i  (idx == last_idx),
      .zchk_i  (cfg_q.zchk),
      .pq_i    (cfg_q.pq_on),
      .data_i  (sel_data),
      .coef_i  (sel_coef),
      .p_o     (p_acc),
      .q_o     (q_acc),
      .pflag_o (pflag),
      .qflag_o (qflag)
   );

   always_comb begin
      out_valid_o = (state == S_EMIT_P) || (state == S_EMIT_Q) || (state == S_FILL);
      out_tag_o   = (state == S_EMIT_Q);
      unique case (state)
         S_EMIT_Q: out_data_o = q_acc;
         S_FILL:   out_data_o = fill_q;
         default:  out_data_o = p_acc;
      endcase
      busy_o       = (state != S_IDLE);
      done_o       = (state == S_DONE);
      irq_o        = done_o && cfg_q.irq_en;
      stat_valid_o = done_o && cfg_q.wback;
      stat_word_o  = {1'b1, pflag, qflag, 5'b0, 24'(cnt_q)};
   end
endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
   parameter int NSRC   = 16,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [31:0]       ctrl_i,
   input logic [NSRC-1:0]   src_valid_i,
   input logic [NSRC-1:0]   src_ready_o,
   input logic [WORD_W-1:0] out_data_o,
   input logic              out_tag_o,
   input logic              out_valid_o,
   input logic              out_ready_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              irq_o,
   input logic              stat_valid_o
);
   logic zchk_q, fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zchk_q <= 1'b0;
         fill_q <= 1'b0;
      end else if (start_i && !busy_o) begin
         zchk_q <= ctrl_i[7];
         fill_q <= ctrl_i[8];
      end
   end

   AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_ready_o)); // R2
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_tag_o)); // R10
   AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ready_o != '0) && ((src_ready_o & src_valid_i) == '0) |=> src_ready_o == $past(src_ready_o)); // R10
   AST_ZCHK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && zchk_q |-> !out_valid_o); // R5
   AST_FILL_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && fill_q && !zchk_q |-> src_ready_o == '0); // R7
   AST_STAT_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid_o |-> done_o); // R6
   AST_IRQ_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> done_o); // R11
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !out_valid_o && !done_o && (src_ready_o == '0)); // R12
endmodule

bind parity_engine pe_checker #(.NSRC(NSRC), .WORD_W(WORD_W)) u_pe_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .ctrl_i       (ctrl_i),
   .src_valid_i  (src_valid_i),
   .src_ready_o  (src_ready_o),
   .out_data_o   (out_data_o),
   .out_tag_o    (out_tag_o),
   .out_valid_o  (out_valid_o),
   .out_ready_i  (out_ready_i),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .irq_o        (irq_o),
   .stat_valid_o (stat_valid_o)
);

// File: tb/parity_engine_test.sv
module parity_engine_test;
   localparam int NS = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [31:0]   ctrl = '0;
   logic [23:0]   bcnt = '0;
   logic [NS*8-1:0]  coef;
   logic [31:0]   fill = '0;
   logic [NS*32-1:0] sdata;
   logic [NS-1:0] svalid, sready;
   logic [31:0]   odata, sword;
   logic          otag, ovalid, busy, done, irq, svld;
   logic          oready = 1'b1;

   int  tests = 0, fails = 0;
   int  dmode = 0;
   bit  stall = 0, throttle = 0, clr = 0;
   int  cyc = 0;
   int  scnt [NS];
   int  nreads = 0, ngot = 0;
   logic [31:0] got_d [0:1023];
   logic        got_t [0:1023];
   logic [7:0]  cf [NS];
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   parity_engine uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .ctrl_i(ctrl), .byte_cnt_i(bcnt),
      .coef_i(coef), .fill_i(fill), .src_data_i(sdata), .src_valid_i(svalid),
      .src_ready_o(sready), .out_data_o(odata), .out_tag_o(otag), .out_valid_o(ovalid),
      .out_ready_i(oready), .busy_o(busy), .done_o(done), .irq_o(irq),
      .stat_valid_o(svld), .stat_word_o(sword)
   );

   function automatic logic [31:0] srcword(int m, int s, int w);
      case (m)
         0: return {8'(s*17 + w), 8'(w*5 + 3), 8'(s + 1), 8'(w ^ (s << 4))};
         1: return 32'h0;
         2: return 32'h11223344 + 32'(w);
         default: return {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
      endcase
   endfunction

   function automatic logic [7:0] gref(logic [7:0] a, logic [7:0] b);
      logic [7:0] r = 0;
      for (int i = 0; i < 8; i++) begin
         if (b[0]) r ^= a;
         b = b >> 1;
         a = a[7] ? ((a << 1) ^ 8'h1D) : (a << 1);
      end
      return r;
   endfunction

   function automatic logic [31:0] exp_p(int m, int n, int w);
      logic [31:0] r = 0;
      for (int s = 0; s < n; s++) r ^= srcword(m, s, w);
      return r;
   endfunction

   function automatic logic [31:0] exp_q(int m, int n, int w);
      logic [31:0] r = 0, d;
      for (int s = 0; s < n; s++) begin
         d = srcword(m, s, w);
         for (int b = 0; b < 4; b++) r[8*b +: 8] ^= gref(d[8*b +: 8], cf[s]);
      end
      return r;
   endfunction

   function automatic logic [31:0] mk(int n, bit pq, bit poff, bit z, bit f, bit wb, bit ie);
      logic [31:0] c = 0;
      c[0] = ie; c[2:1] = 2'b11; c[6:3] = 4'(n - 1); c[7] = z; c[8] = f;
      c[12] = wb; c[17] = pq; c[18] = poff;
      return c;
   endfunction

   always_comb begin
      for (int s = 0; s < NS; s++) begin
         sdata[s*32 +: 32] = srcword(dmode, s, scnt[s]);
         svalid[s] = !(stall && (((scnt[s] + s + cyc) % 3) == 0));
         coef[s*8 +: 8] = cf[s];
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (clr) begin
         for (int s = 0; s < NS; s++) scnt[s] <= 0;
         nreads <= 0;
         ngot <= 0;
      end else begin
         for (int s = 0; s < NS; s++)
            if (svalid[s] && sready[s]) scnt[s] <= scnt[s] + 1;
         if ((svalid & sready) != '0) nreads <= nreads + 1;
         if (ovalid && oready) begin
            got_d[ngot] <= odata;
            got_t[ngot] <= otag;
            ngot <= ngot + 1;
         end
      end
   end

   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      oready <= throttle ? lfsr[0] : 1'b1;
   end

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   bit          r_sv, r_irq;
   logic [31:0] r_sw;
   int          r_lat;

   task automatic run(logic [31:0] c, int n);
      @(negedge clk);
      clr = 1; ctrl = c; bcnt = 24'(n); start = 1;
      @(negedge clk);
      clr = 0; start = 0; ctrl = '1;
      r_lat = 1;
      while (!done && r_lat < 20000) begin
         @(negedge clk);
         r_lat++;
      end
      r_sv = svld; r_sw = sword; r_irq = irq;
      if (!done) chk(0, "R12", "completion timeout", 0, 1);
      @(negedge clk);
   endtask

   task automatic stream(string req, int n, bit pq, bit poff, int cnt);
      int k = 0, bad = 0;
      logic [31:0] ed, fd = 0, fe = 0;
      bit et;
      for (int w = 0; w < (cnt + 3) / 4; w++) begin
         for (int h = 0; h < 2; h++) begin
            if (h == 0 && pq && poff) continue;
            if (h == 1 && !pq) continue;
            ed = (h == 0) ? exp_p(dmode, n, w) : exp_q(dmode, n, w);
            et = (h == 1);
            if (k < ngot && (got_d[k] !== ed || got_t[k] !== et)) begin
               if (bad == 0) begin fd = got_d[k]; fe = ed; end
               bad++;
            end
            k++;
         end
      end
      chk(ngot == k, req, "word count", 32'(ngot), 32'(k));
      chk(bad == 0, req, "word values", fd, fe);
   endtask

   initial begin
      #(4 * 200000);
      fails++; tests++;
      $display("FAIL R12 watchdog expired: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int s = 0; s < NS; s++) cf[s] = 8'(s * 29 + 3);
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(!busy && !done, "R12", "busy/done after reset", {30'b0, busy, done}, 0);
      chk(!ovalid, "R12", "out_valid after reset", 32'(ovalid), 0);
      chk(sready == '0, "R12", "src_ready after reset", 32'(sready), 0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && sready == '0, "R12", "idle after release", 32'(sready), 0);

      // R2 single source
      dmode = 0;
      run(mk(1, 0, 0, 0, 0, 0, 0), 12);
      stream("R2", 1, 0, 0, 12);
      // R1 R2 R10 sixteen sources with stalls on both sides
      stall = 1; throttle = 1;
      run(mk(16, 0, 1, 0, 0, 0, 0), 20);
      stream("R1", 16, 0, 0, 20);
      // R3 R10 P+Q five sources
      run(mk(5, 1, 0, 0, 0, 0, 0), 16);
      stream("R3", 5, 1, 0, 16);
      // R4 P suppressed
      run(mk(3, 1, 1, 0, 0, 0, 0), 24);
      stream("R4", 3, 1, 1, 24);
      stall = 0; throttle = 0;
      // R8 rounding up of partial words
      run(mk(2, 0, 0, 0, 0, 0, 0), 7);
      stream("R8", 2, 0, 0, 7);
      run(mk(4, 1, 0, 0, 0, 0, 0), 1);
      stream("R8", 4, 1, 0, 1);

      // R5 R6 zero-check: both nonzero
      run(mk(4, 1, 0, 1, 0, 1, 0), 32);
      chk(ngot == 0, "R5", "no output in check mode", 32'(ngot), 0);
      chk(r_sv && r_sw == 32'hE000_0020, "R6", "status both nonzero", r_sw, 32'hE000_0020);
      // all-zero data
      dmode = 1;
      run(mk(4, 1, 0, 1, 0, 1, 0), 16);
      chk(r_sw == 32'h8000_0010, "R5", "status all zero", r_sw, 32'h8000_0010);
      // P cancels, Q does not
      dmode = 2; cf[0] = 8'd1; cf[1] = 8'd2;
      run(mk(2, 1, 0, 1, 0, 1, 0), 12);
      chk(r_sw == 32'hA000_000C, "R5", "status Q only", r_sw, 32'hA000_000C);
      // Q flag ignored without P+Q
      run(mk(2, 0, 0, 1, 0, 1, 0), 12);
      chk(r_sw == 32'h8000_000C, "R5", "status without P+Q", r_sw, 32'h8000_000C);
      // no write-back
      run(mk(2, 0, 0, 0, 0, 0, 0), 8);
      chk(!r_sv, "R6", "status absent without write-back", 32'(r_sv), 0);

      // R7 fill
      dmode = 0; fill = 32'hC0FFEE11; throttle = 1;
      run(mk(8, 0, 0, 0, 1, 0, 0), 10);
      begin
         int bad = 0;
         for (int k = 0; k < ngot; k++) if (got_d[k] !== 32'hC0FFEE11 || got_t[k]) bad++;
         chk(ngot == 3, "R7", "fill word count", 32'(ngot), 3);
         chk(bad == 0, "R7", "fill value", 32'(bad), 0);
         chk(nreads == 0, "R7", "no source reads in fill", 32'(nreads), 0);
      end
      throttle = 0;

      // R9 zero byte count
      run(mk(4, 1, 0, 0, 0, 1, 0), 0);
      chk(r_lat == 2, "R9", "done latency", 32'(r_lat), 2);
      chk(ngot == 0 && nreads == 0, "R9", "no data moved", 32'(ngot + nreads), 0);
      chk(r_sv && r_sw == 32'h8000_0000, "R9", "status word", r_sw, 32'h8000_0000);

      // R11 interrupt
      run(mk(1, 0, 0, 0, 0, 0, 1), 4);
      chk(r_irq, "R11", "irq with enable", 32'(r_irq), 1);
      run(mk(1, 0, 0, 0, 0, 0, 0), 4);
      chk(!r_irq, "R11", "irq without enable", 32'(r_irq), 0);

      // R3 exhaustive coefficient by byte sweep, Q only
      dmode = 3;
      for (int c = 0; c < 256; c++) begin
         int bad = 0;
         cf[0] = 8'(c);
         run(mk(1, 1, 1, 0, 0, 0, 0), 256);
         for (int w = 0; w < 64; w++)
            for (int b = 0; b < 4; b++)
               if (got_d[w][8*b +: 8] !== gref(8'(4*w + b), 8'(c))) bad++;
         chk(ngot == 64 && bad == 0, "R3", $sformatf("GF sweep coef %0d", c), 32'(bad), 0);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule